// File: doc/BRIEF.md
# Edge-Captured Interrupt Status Controller

This block watches four single-bit detector lines: left jack present, right jack present, microphone short-circuit and microphone present. Each line is brought into the local clock domain through a two-flop synchroniser. Any change of level, rising or falling, is caught in a sticky status bit. A mask register gates the pending bits onto one interrupt line that feeds a higher-level interrupt collector.

Software reaches the block through a small register port with separate read and write strobes. A read of the status register returns the pending bits and clears them in the same cycle. The mask register can be written and read back. A masked source still records its events. Masking only keeps them off the interrupt line, so software can poll for them or unmask them later and get the interrupt at once.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset all status bits and all mask bits are 0, `irq_o` is 0 and `reg_rdata_o` is 0.
- R2: A rising level on a source line that is stable before clock edge k sets that source's status bit at edge k+2, and not earlier. Status bit order is: bit 11 left jack, bit 10 right jack, bit 9 mic short, bit 8 mic present (source index 3 down to 0).
- R3: A falling level on a source line sets its status bit with the same timing as a rising one.
- R4: A read strobe at address 0 loads the status bits into `reg_rdata_o[11:8]` at the next edge and clears them at that same edge. All other data bits read as 0.
- R5: If a source event reaches the status register at the same edge as a status read, the read returns the old value and the bit stays set after the read.
- R6: The mask register sits at address 1, bits 11:8, in the same order as the status bits. Writes load it, reads return it, and every other bit reads as 0.
- R7: A mask bit of 1 keeps its source off `irq_o`, but events from that source are still recorded in the status register.
- R8: `irq_o` is 1 exactly when some status bit is set and its mask bit is 0. Clearing the mask of a pending bit raises `irq_o` after the write edge.
- R9: Writes to the status address change no status bit.
- R10: Addresses 2 and 3 read as 0, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 4 | Detector lines, index 3 = left jack … index 0 = mic present |
| reg_addr_i | input | 2 | Register address: 0 status, 1 mask |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Registered read data, held until the next read |
| irq_o | output | 1 | First-level interrupt, active high |

## Verification
A level change on a source line reaches the status register two edges after it is first sampled. The bench therefore drives stimulus at a falling clock edge. It checks that `irq_o` is still low after two rising edges and high after the third. Read data and the clearing of status both appear one edge after the read strobe, and a mask write acts on `irq_o` one edge after the strobe. All outputs are sampled at the falling edge that follows the relevant rising edge. The coincident-read case puts the read strobe on the very edge at which the event lands. The bench then expects the old value back and the bit to still be pending.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int unsigned SRC_COUNT   = 4;
    localparam int unsigned REG_DATA_W  = 16;
    localparam int unsigned REG_ADDR_W  = 2;
    localparam int unsigned FIELD_LSB   = 8;

    localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_MASK   = 2'd1;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/evt_irq_capture.sv
module evt_irq_capture #(
    parameter int unsigned W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] level_i,
    input  logic         clear_i,
    output logic [W-1:0] event_o,
    output logic [W-1:0] status_o
);

    typedef struct packed {
        logic [W-1:0] last;
        logic [W-1:0] pend;
    } cap_state_t;

    cap_state_t   st_d, st_q;
    logic [W-1:0] chg;

    // one change detector per source line
    for (genvar g = 0; g < W; g++) begin : g_det
        assign chg[g] = level_i[g] ^ st_q.last[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.last = level_i;
        if (clear_i) begin
            st_d.pend = chg;          // new events win over the clear
        end else begin
            st_d.pend = st_q.pend | chg;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o  = chg;
    assign status_o = st_q.pend;

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int unsigned W      = SRC_COUNT,
    parameter int unsigned DATA_W = REG_DATA_W,
    parameter int unsigned ADDR_W = REG_ADDR_W,
    parameter int unsigned LSB    = FIELD_LSB,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_STATUS,
    parameter logic [ADDR_W-1:0] MSK_ADDR  = ADDR_MASK
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [W-1:0]      status_i,
    output logic              clear_o,
    output logic [W-1:0]      mask_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [DATA_W-1:0] FIELD_BITS = {{(DATA_W-W){1'b0}}, {W{1'b1}}} << LSB;

    typedef struct packed {
        logic [W-1:0]      mask;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t st_d, st_q;
    reg_sel_e   sel;
    logic       unused_wdata;

    assign unused_wdata = ^(wdata_i & ~FIELD_BITS);

    always_comb begin
        if (addr_i == STAT_ADDR) begin
            sel = SEL_STATUS;
        end else if (addr_i == MSK_ADDR) begin
            sel = SEL_MASK;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_i && sel == SEL_MASK) begin
            st_d.mask = wdata_i[LSB +: W];
        end
        if (rd_i) begin
            st_d.rdata = '0;
            unique case (sel)
                SEL_STATUS: st_d.rdata[LSB +: W] = status_i;
                SEL_MASK:   st_d.rdata[LSB +: W] = st_q.mask;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clear_o = rd_i && (sel == SEL_STATUS);
    assign mask_o  = st_q.mask;
    assign rdata_o = st_q.rdata;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_COUNT,
    parameter int unsigned DATA_W  = REG_DATA_W,
    parameter int unsigned ADDR_W  = REG_ADDR_W,
    parameter int unsigned LSB     = FIELD_LSB
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    localparam int unsigned FIELD_TOP = LSB + NUM_SRC;

    if (FIELD_TOP > DATA_W) begin : g_bad_field
        initial $error("status field does not fit the data word");
    end

    logic [NUM_SRC-1:0] level_w;
    logic [NUM_SRC-1:0] event_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] mask_w;
    logic               clear_w;

    evt_irq_sync #(.W(NUM_SRC)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (level_w)
    );

    evt_irq_capture #(.W(NUM_SRC)) u_cap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .level_i  (level_w),
        .clear_i  (clear_w),
        .event_o  (event_w),
        .status_o (status_w)
    );

    evt_irq_regs #(
        .W      (NUM_SRC),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .LSB    (LSB)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .wdata_i  (reg_wdata_i),
        .status_i (status_w),
        .clear_o  (clear_w),
        .mask_o   (mask_w),
        .rdata_o  (reg_rdata_o)
    );

    assign irq_o = |(status_w & ~mask_w);

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
    parameter int unsigned W      = 4,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned LSB    = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [W-1:0]      event_w,
    input logic [W-1:0]      status_w,
    input logic [W-1:0]      mask_w
);

    localparam logic [DATA_W-1:0] FIELD_BITS = {{(DATA_W-W){1'b0}}, {W{1'b1}}} << LSB;

    // R2: every detected event is recorded at the next edge
    assert_event_recorded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|event_w) |=> ((status_w & $past(event_w)) == $past(event_w)));

    // R2: no status bit appears without an event the cycle before
    assert_no_spurious_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_w & ~$past(status_w) & ~$past(event_w)) == '0));

    // R4: a status read with no new event leaves nothing pending
    assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_addr_i == '0 && event_w == '0) |=> (status_w == '0));

    // R6: read data outside the field is always zero
    assert_rdata_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((reg_rdata_o & ~FIELD_BITS) == '0));

    // R7: with every source masked the line stays quiet
    assert_full_mask_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&mask_w) |-> !irq_o);

    // R9: a write to the status address without read or event keeps status
    assert_status_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !reg_rd_i && reg_addr_i == '0 && event_w == '0) |=> $stable(status_w));

endmodule

bind evt_irq_ctrl evt_irq_chk #(
    .W      (NUM_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LSB    (LSB)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .event_w     (event_w),
    .status_w    (status_w),
    .mask_w      (mask_w)
);

// File: tb/sim_evt_irq_ctrl.sv
module sim_evt_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_irq_ctrl u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // {src[3:0], mask[3:0], expected status[3:0], expected irq}
    localparam logic [12:0] VEC [8] = '{
        {4'b0001, 4'b0000, 4'b0001, 1'b1},
        {4'b0011, 4'b0000, 4'b0010, 1'b1},
        {4'b1100, 4'b0000, 4'b1111, 1'b1},
        {4'b1101, 4'b0001, 4'b0001, 1'b0},
        {4'b0101, 4'b1000, 4'b1000, 1'b0},
        {4'b0000, 4'b0000, 4'b0101, 1'b1},
        {4'b1010, 4'b0101, 4'b1010, 1'b1},
        {4'b1010, 4'b0000, 4'b0000, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        addr = a; rd = 1'b1;
        tick();
        d = rdata;
        rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [3:0]  prev;
        tick(); tick();
        chk("R1 irq in reset", {15'd0, irq}, 16'd0);
        chk("R1 rdata in reset", rdata, 16'd0);
        rst_n = 1'b1;
        tick();
        reg_read(2'd0, d); chk("R1 status after reset", d, 16'h0000);
        reg_read(2'd1, d); chk("R1 mask after reset", d, 16'h0000);

        // vector walk
        prev = 4'b0000;
        for (int i = 0; i < 8; i++) begin
            logic [3:0] vs, vm, ve;
            logic       vi;
            {vs, vm, ve, vi} = VEC[i];
            chk("R2_R3 table consistency", {12'd0, prev ^ vs}, {12'd0, ve});
            reg_write(2'd1, {4'd0, vm, 8'd0});
            src = vs;
            tick(); tick();
            chk("R2 no early irq", {15'd0, irq}, 16'd0);
            tick();
            chk("R8 R7 irq after event", {15'd0, irq}, {15'd0, vi});
            reg_read(2'd0, d);
            chk("R2 R3 R7 status read", d, {4'd0, ve, 8'd0});
            chk("R4 irq after clearing read", {15'd0, irq}, 16'd0);
            prev = vs;
        end

        // R6 mask readback and zero padding
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, d); chk("R6 mask readback", d, 16'h0F00);
        reg_write(2'd1, 16'h0000);

        // R9 status writes ignored
        src = 4'b1011;
        tick(); tick(); tick();
        reg_write(2'd0, 16'hFFFF);
        reg_write(2'd0, 16'h0000);
        chk("R9 irq still pending", {15'd0, irq}, 16'd1);
        reg_read(2'd0, d); chk("R9 status unchanged by writes", d, 16'h0100);

        // R5 event lands on the read edge
        src = 4'b0011;
        tick(); tick();
        reg_read(2'd0, d); chk("R5 read returns old value", d, 16'h0000);
        chk("R5 irq kept", {15'd0, irq}, 16'd1);
        reg_read(2'd0, d); chk("R5 bit survived read", d, 16'h0800);
        reg_read(2'd0, d); chk("R4 second read empty", d, 16'h0000);

        // R8 unmasking a pending bit
        reg_write(2'd1, 16'h0F00);
        src = 4'b0001;
        tick(); tick(); tick();
        chk("R7 masked irq low", {15'd0, irq}, 16'd0);
        reg_write(2'd1, 16'h0000);
        chk("R8 irq after unmask", {15'd0, irq}, 16'd1);
        reg_read(2'd0, d); chk("R7 masked event recorded", d, 16'h0200);

        // R10 unmapped addresses
        reg_write(2'd3, 16'hFFFF);
        reg_write(2'd2, 16'hFFFF);
        reg_read(2'd1, d); chk("R10 mask untouched", d, 16'h0000);
        reg_read(2'd3, d); chk("R10 addr 3 reads zero", d, 16'h0000);
        reg_read(2'd2, d); chk("R10 addr 2 reads zero", d, 16'h0000);

        // R1 reset mid-run clears pending state
        src = 4'b0101;
        tick(); tick(); tick();
        chk("R2 pending before reset", {15'd0, irq}, 16'd1);
        rst_n = 1'b0;
        tick();
        chk("R1 irq cleared by reset", {15'd0, irq}, 16'd0);
        src = 4'b0000;
        tick();
        rst_n = 1'b1;
        tick(); tick(); tick();
        reg_read(2'd0, d); chk("R1 status empty after reset", d, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule